// File: doc/BRIEF.md
# Byte-Wise Memory Write-Verify Checker

This block exercises a request/response memory port on its own. It holds one base address and an 8-bit seed. Each time the surrounding logic pulses `initiate`, the block takes one step. It either writes the next single byte of a short run, where each byte is the seed plus its offset modulo 256, or it reads the whole run back in one request. When the read returns, the block compares every byte against the expected pattern. Matching runs increment a completion counter and draw a fresh seed from an internal LFSR. A mismatch, or a response the block was not waiting for, latches an error together with its details.

Each request goes out on a port index chosen pseudo-randomly. Writes use a writer port and reads use a reader port. Reader ports are classed by parameter as data-only, shared, or instruction-only, and that class decides the instruction-fetch marking on a read. When flush testing is enabled, an initiate occasionally produces a flush request for the whole run instead of the normal step. The memory under test is not part of the block.

Top module: `wv_checker`

## Requirements
- R1: After a synchronous reset, `req_valid`, `error_flag` and `pass_count` are 0 and `err_kind` is 0 (none).
- R2: In the idle step an initiate produces one registered request cycle: `req_kind`=0 (write), `req_len`=1, `req_addr`=base+n, `req_wdata`=(seed+n) mod 256, `req_ifetch`=0, and `req_port` below the writer count. Here n is the number of bytes already written in the run.
- R3: The step advances only when `req_ready` is high in the cycle `req_valid` is high. If the port does not take the request, the next initiate re-issues the same address and data.
- R4: Once CHECK_SIZE write responses have arrived, the next initiate issues `req_kind`=1 (read) at the base address with `req_len`=CHECK_SIZE and `req_port` below the reader count.
- R5: A read response in which byte i (bits 8i+7..8i of `rsp_rdata`) equals seed+i for every i increments `pass_count`. The next run then starts again at offset 0 of the base address.
- R6: On a read mismatch, `error_flag` rises and `err_kind`=1 (mismatch). `err_index` holds the lowest failing byte, `err_expected` holds seed+index, `err_actual` holds the received byte, and `pass_count` is unchanged. The error is sticky until reset, and the first error's details are kept.
- R7: A response arriving while no write or read is outstanding sets `error_flag` with `err_kind`=2 (unexpected).
- R8: An initiate while a write or read is outstanding produces no request.
- R9: With `flush_en` low, no flush is ever issued. With it high, an initiate with the LFSR's low byte at zero issues `req_kind`=2 (flush) at the base address with `req_len`=CHECK_SIZE on a writer port, and the write/read sequence is left where it was.
- R10: A read on an instruction-only reader port (by default port 2) has `req_ifetch`=1. A read on a data-only port (by default port 0) has `req_ifetch`=0. A read on a shared port (by default port 1) takes a pseudo-random marking.
- R11: `load_addr` sets a new base address only when no write or read is outstanding and no request cycle is in progress. Loading returns the sequence to the first byte and keeps the seed. In any other case `load_addr` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| initiate | input | 1 | Take one step of the sequence |
| flush_en | input | 1 | Allow random flush requests |
| load_addr | input | 1 | Load a new base address |
| new_addr | input | ADDR_W | Base address to load |
| req_valid | output | 1 | Request cycle present |
| req_ready | input | 1 | Port takes the request this cycle |
| req_kind | output | 2 | 0 write, 1 read, 2 flush |
| req_addr | output | ADDR_W | Request byte address |
| req_len | output | LEN_W | Request length in bytes |
| req_wdata | output | 8 | Write byte |
| req_port | output | PORT_W | Chosen writer or reader port index |
| req_ifetch | output | 1 | Read marked as instruction fetch |
| rsp_valid | input | 1 | Response from the port |
| rsp_rdata | input | 8*CHECK_SIZE | Read data, byte i in bits 8i+7..8i |
| pass_count | output | CNT_W | Completed matching checks |
| error_flag | output | 1 | Sticky error |
| err_kind | output | 2 | 0 none, 1 mismatch, 2 unexpected |
| err_index | output | IDX_W | Lowest mismatching byte |
| err_expected | output | 8 | Expected byte at that index |
| err_actual | output | 8 | Received byte at that index |

## Verification
A wrong byte counter shows at the port on the very next write request, as an address or data value off by one from the previous write. It shows again at the read, which would come too early or too late. A state register stuck or skipping shows within one initiate: a request appears where none is allowed, an expected one is missing, or a good response is flagged as unexpected. A corrupted seed or comparator appears when the read response is registered, as a changed `pass_count` or a raised `error_flag` carrying its index and byte values.

// File: rtl/wv_pkg.sv
package wv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_ACT_PEND = 2'd1,
    ST_READY    = 2'd2,
    ST_CHK_PEND = 2'd3
  } wv_state_e;

  localparam logic [1:0] KIND_WRITE = 2'd0;
  localparam logic [1:0] KIND_READ  = 2'd1;
  localparam logic [1:0] KIND_FLUSH = 2'd2;

  localparam logic [1:0] ERR_NONE       = 2'd0;
  localparam logic [1:0] ERR_MISMATCH   = 2'd1;
  localparam logic [1:0] ERR_UNEXPECTED = 2'd2;
endpackage

// File: rtl/wv_lfsr.sv
module wv_lfsr #(
  parameter int          W     = 16,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst) value <= SEED;
    else     value <= {1'b0, value[W-1:1]} ^ (value[0] ? TAPS : '0);
  end
endmodule

// File: rtl/wv_cmp.sv
module wv_cmp #(
  parameter int CHECK_SIZE = 4,
  parameter int IDX_W      = 2
) (
  input  logic [7:0]              seed,
  input  logic [8*CHECK_SIZE-1:0] data,
  output logic                    bad,
  output logic [IDX_W-1:0]        idx,
  output logic [7:0]              exp_byte,
  output logic [7:0]              act_byte
);
  logic [CHECK_SIZE-1:0] mis;

  for (genvar i = 0; i < CHECK_SIZE; i++) begin : g_byte
    assign mis[i] = data[8*i +: 8] != 8'(seed + 8'(i));
  end

  always_comb begin
    bad      = |mis;
    idx      = '0;
    exp_byte = seed;
    act_byte = data[7:0];
    for (int i = CHECK_SIZE - 1; i >= 0; i--) begin
      if (mis[i]) begin
        idx      = IDX_W'(i);
        exp_byte = 8'(seed + 8'(i));
        act_byte = data[8*i +: 8];
      end
    end
  end
endmodule

// File: rtl/wv_seq.sv
module wv_seq
  import wv_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int CHECK_SIZE  = 4,
  parameter int NUM_WRITERS = 2,
  parameter int NUM_READERS = 3,
  parameter logic [NUM_READERS-1:0] READER_IFETCH_ONLY = 3'b100,
  parameter logic [NUM_READERS-1:0] READER_SHARED      = 3'b010,
  parameter int CNT_W       = 16,
  parameter logic [7:0] SEED_INIT = 8'h5A,
  parameter int LEN_W       = 3,
  parameter int IDX_W       = 2,
  parameter int PORT_W      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              initiate,
  input  logic              flush_en,
  input  logic              load_addr,
  input  logic [ADDR_W-1:0] new_addr,
  input  logic [15:0]       rnd,
  input  logic              cmp_bad,
  input  logic [IDX_W-1:0]  cmp_idx,
  input  logic [7:0]        cmp_exp,
  input  logic [7:0]        cmp_act,
  input  logic              req_ready,
  input  logic              rsp_valid,
  output logic              req_valid,
  output logic [1:0]        req_kind,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic [7:0]        req_wdata,
  output logic [PORT_W-1:0] req_port,
  output logic              req_ifetch,
  output logic [7:0]        seed_o,
  output logic [CNT_W-1:0]  pass_count,
  output logic              error_flag,
  output logic [1:0]        err_kind,
  output logic [IDX_W-1:0]  err_index,
  output logic [7:0]        err_expected,
  output logic [7:0]        err_actual
);
  wv_state_e         state;
  logic [ADDR_W-1:0] base;
  logic [LEN_W-1:0]  cnt;
  logic [7:0]        seed;

  logic              can_start, flush_hit, last_byte, load_ok, ifetch_pick;
  logic [PORT_W-1:0] wsel, rsel;

  assign seed_o    = seed;
  assign can_start = (state == ST_IDLE) || (state == ST_READY);
  assign flush_hit = flush_en && (rnd[7:0] == 8'h00);
  assign last_byte = cnt == LEN_W'(CHECK_SIZE - 1);
  assign load_ok   = load_addr && can_start && !req_valid;
  assign wsel      = PORT_W'(rnd[15:8] % 8'(NUM_WRITERS));
  assign rsel      = PORT_W'(rnd[14:7] % 8'(NUM_READERS));

  always_comb begin
    ifetch_pick = 1'b0;
    for (int p = 0; p < NUM_READERS; p++) begin
      if (rsel == PORT_W'(p))
        ifetch_pick = READER_IFETCH_ONLY[p] | (READER_SHARED[p] & rnd[3]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      base         <= '0;
      cnt          <= '0;
      seed         <= SEED_INIT;
      req_valid    <= 1'b0;
      req_kind     <= KIND_WRITE;
      req_addr     <= '0;
      req_len      <= '0;
      req_wdata    <= '0;
      req_port     <= '0;
      req_ifetch   <= 1'b0;
      pass_count   <= '0;
      error_flag   <= 1'b0;
      err_kind     <= ERR_NONE;
      err_index    <= '0;
      err_expected <= '0;
      err_actual   <= '0;
    end else begin
      req_valid <= 1'b0;
      if (req_valid) begin
        if (req_ready && req_kind != KIND_FLUSH)
          state <= (req_kind == KIND_WRITE) ? ST_ACT_PEND : ST_CHK_PEND;
      end else if (initiate && can_start && !load_addr) begin
        req_valid <= 1'b1;
        if (flush_hit) begin
          req_kind   <= KIND_FLUSH;
          req_addr   <= base;
          req_len    <= LEN_W'(CHECK_SIZE);
          req_wdata  <= '0;
          req_port   <= wsel;
          req_ifetch <= 1'b0;
        end else if (state == ST_IDLE) begin
          req_kind   <= KIND_WRITE;
          req_addr   <= base + ADDR_W'(cnt);
          req_len    <= LEN_W'(1);
          req_wdata  <= 8'(seed + 8'(cnt));
          req_port   <= wsel;
          req_ifetch <= 1'b0;
        end else begin
          req_kind   <= KIND_READ;
          req_addr   <= base;
          req_len    <= LEN_W'(CHECK_SIZE);
          req_wdata  <= '0;
          req_port   <= rsel;
          req_ifetch <= ifetch_pick;
        end
      end

      if (rsp_valid) begin
        case (state)
          ST_ACT_PEND: begin
            cnt   <= cnt + LEN_W'(1);
            state <= last_byte ? ST_READY : ST_IDLE;
          end
          ST_CHK_PEND: begin
            if (cmp_bad) begin
              error_flag <= 1'b1;
              if (!error_flag) begin
                err_kind     <= ERR_MISMATCH;
                err_index    <= cmp_idx;
                err_expected <= cmp_exp;
                err_actual   <= cmp_act;
              end
            end else begin
              pass_count <= pass_count + CNT_W'(1);
            end
            state <= ST_IDLE;
            seed  <= rnd[7:0];
            cnt   <= '0;
          end
          default: begin
            error_flag <= 1'b1;
            if (!error_flag) err_kind <= ERR_UNEXPECTED;
          end
        endcase
      end

      if (load_ok) begin
        base  <= new_addr;
        cnt   <= '0;
        state <= ST_IDLE;
      end
    end
  end

  assert_write_taken_R3: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && req_kind == KIND_WRITE |=> state == ST_ACT_PEND);

  assert_busy_hold_R3: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> $stable(state));

  assert_run_done_R4: assert property (@(posedge clk) disable iff (rst)
    state == ST_ACT_PEND && rsp_valid && last_byte |=> state == ST_READY);

  assert_count_only_on_read_R5: assert property (@(posedge clk) disable iff (rst)
    !(state == ST_CHK_PEND && rsp_valid) |=> $stable(pass_count));

  assert_error_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    error_flag |=> error_flag);

  assert_stray_response_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && can_start |=> error_flag);
endmodule

// File: rtl/wv_checker.sv
module wv_checker
  import wv_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int CHECK_SIZE  = 4,
  parameter int NUM_WRITERS = 2,
  parameter int NUM_READERS = 3,
  parameter logic [NUM_READERS-1:0] READER_IFETCH_ONLY = 3'b100,
  parameter logic [NUM_READERS-1:0] READER_SHARED      = 3'b010,
  parameter int CNT_W       = 16,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  parameter logic [7:0]  SEED_INIT = 8'h5A,
  localparam int LEN_W  = $clog2(CHECK_SIZE + 1),
  localparam int IDX_W  = (CHECK_SIZE > 1) ? $clog2(CHECK_SIZE) : 1,
  localparam int NPORT  = (NUM_WRITERS > NUM_READERS) ? NUM_WRITERS : NUM_READERS,
  localparam int PORT_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    initiate,
  input  logic                    flush_en,
  input  logic                    load_addr,
  input  logic [ADDR_W-1:0]       new_addr,
  output logic                    req_valid,
  input  logic                    req_ready,
  output logic [1:0]              req_kind,
  output logic [ADDR_W-1:0]       req_addr,
  output logic [LEN_W-1:0]        req_len,
  output logic [7:0]              req_wdata,
  output logic [PORT_W-1:0]       req_port,
  output logic                    req_ifetch,
  input  logic                    rsp_valid,
  input  logic [8*CHECK_SIZE-1:0] rsp_rdata,
  output logic [CNT_W-1:0]        pass_count,
  output logic                    error_flag,
  output logic [1:0]              err_kind,
  output logic [IDX_W-1:0]        err_index,
  output logic [7:0]              err_expected,
  output logic [7:0]              err_actual
);
  logic [15:0]      rnd;
  logic [7:0]       seed;
  logic             cmp_bad;
  logic [IDX_W-1:0] cmp_idx;
  logic [7:0]       cmp_exp, cmp_act;

  wv_lfsr #(.W(16), .SEED(LFSR_SEED), .TAPS(16'hB400)) u_lfsr (
    .clk(clk), .rst(rst), .value(rnd)
  );

  wv_cmp #(.CHECK_SIZE(CHECK_SIZE), .IDX_W(IDX_W)) u_cmp (
    .seed(seed), .data(rsp_rdata), .bad(cmp_bad), .idx(cmp_idx),
    .exp_byte(cmp_exp), .act_byte(cmp_act)
  );

  wv_seq #(
    .ADDR_W(ADDR_W), .CHECK_SIZE(CHECK_SIZE), .NUM_WRITERS(NUM_WRITERS),
    .NUM_READERS(NUM_READERS), .READER_IFETCH_ONLY(READER_IFETCH_ONLY),
    .READER_SHARED(READER_SHARED), .CNT_W(CNT_W), .SEED_INIT(SEED_INIT),
    .LEN_W(LEN_W), .IDX_W(IDX_W), .PORT_W(PORT_W)
  ) u_seq (
    .clk(clk), .rst(rst), .initiate(initiate), .flush_en(flush_en),
    .load_addr(load_addr), .new_addr(new_addr), .rnd(rnd),
    .cmp_bad(cmp_bad), .cmp_idx(cmp_idx), .cmp_exp(cmp_exp), .cmp_act(cmp_act),
    .req_ready(req_ready), .rsp_valid(rsp_valid),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .req_len(req_len), .req_wdata(req_wdata), .req_port(req_port),
    .req_ifetch(req_ifetch), .seed_o(seed), .pass_count(pass_count),
    .error_flag(error_flag), .err_kind(err_kind), .err_index(err_index),
    .err_expected(err_expected), .err_actual(err_actual)
  );
endmodule

// File: tb/sim_wv_checker.sv
module sim_wv_checker;
  localparam int CS = 4;
  localparam int NW = 2;
  localparam int NR = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        initiate = 1'b0, flush_en = 1'b0, load_addr = 1'b0;
  logic [15:0] new_addr = '0;
  logic        req_ready = 1'b0, rsp_valid = 1'b0;
  logic [8*CS-1:0] rsp_rdata = '0;
  logic        req_valid, req_ifetch, error_flag;
  logic [1:0]  req_kind, err_kind;
  logic [15:0] req_addr, pass_count;
  logic [2:0]  req_len;
  logic [7:0]  req_wdata, err_expected, err_actual;
  logic [1:0]  req_port, err_index;

  always #2 clk = ~clk;

  wv_checker u0 (
    .clk(clk), .rst(rst), .initiate(initiate), .flush_en(flush_en),
    .load_addr(load_addr), .new_addr(new_addr), .req_valid(req_valid),
    .req_ready(req_ready), .req_kind(req_kind), .req_addr(req_addr),
    .req_len(req_len), .req_wdata(req_wdata), .req_port(req_port),
    .req_ifetch(req_ifetch), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .pass_count(pass_count), .error_flag(error_flag), .err_kind(err_kind),
    .err_index(err_index), .err_expected(err_expected), .err_actual(err_actual)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] mem [256];
  logic [7:0] cur_seed;
  bit         c_seen;
  logic [1:0] c_kind;
  logic [15:0] c_addr;
  logic [2:0] c_len;
  logic [7:0] c_wdata;
  logic [1:0] c_port;
  logic       c_ifetch;

  // {base[15:0], busy_first_retry, initiate_while_pending}
  localparam logic [17:0] VEC [6] = '{
    {16'h0010, 1'b0, 1'b0}, {16'h0040, 1'b1, 1'b0}, {16'h0080, 1'b0, 1'b1},
    {16'h00C3, 1'b1, 1'b1}, {16'h0020, 1'b0, 1'b0}, {16'h00F0, 1'b1, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic issue(input bit accept);
    @(negedge clk) initiate = 1'b1;
    @(negedge clk) initiate = 1'b0;
    c_seen = req_valid; c_kind = req_kind; c_addr = req_addr; c_len = req_len;
    c_wdata = req_wdata; c_port = req_port; c_ifetch = req_ifetch;
    req_ready = accept;
    @(negedge clk) req_ready = 1'b0;
  endtask

  task automatic respond(input logic [8*CS-1:0] d);
    @(negedge clk) begin rsp_valid = 1'b1; rsp_rdata = d; end
    @(negedge clk) rsp_valid = 1'b0;
  endtask

  task automatic load(input logic [15:0] a);
    @(negedge clk) begin load_addr = 1'b1; new_addr = a; end
    @(negedge clk) load_addr = 1'b0;
  endtask

  task automatic write_step(input logic [15:0] base, input int k);
    issue(1'b1);
    if (k == 0) cur_seed = c_wdata;
    chk(c_seen && c_kind == 2'd0, "R2 write request kind", int'(c_kind), 0);
    chk(c_addr == base + 16'(k), "R2 write address", int'(c_addr), int'(base) + k);
    chk(c_wdata == 8'(cur_seed + 8'(k)) && c_len == 3'd1 && !c_ifetch,
        "R2 write data/len", int'(c_wdata), int'(8'(cur_seed + 8'(k))));
    chk(int'(c_port) < NW, "R2 writer port", int'(c_port), NW - 1);
    mem[c_addr[7:0]] = c_wdata;
  endtask

  task automatic read_step(input logic [15:0] base, output logic [8*CS-1:0] d);
    issue(1'b1);
    chk(c_seen && c_kind == 2'd1 && c_addr == base && c_len == 3'(CS),
        "R4 read request", int'(c_addr), int'(base));
    chk(int'(c_port) < NR, "R4 reader port", int'(c_port), NR - 1);
    if (c_port == 2'd2) chk(c_ifetch == 1'b1, "R10 ifetch-only port", int'(c_ifetch), 1);
    if (c_port == 2'd0) chk(c_ifetch == 1'b0, "R10 data-only port", int'(c_ifetch), 0);
    for (int i = 0; i < CS; i++) d[8*i +: 8] = mem[8'(base[7:0] + 8'(i))];
  endtask

  task automatic run_check(input logic [15:0] base, input bit busy, input bit poke,
                           input int bad_idx, input logic [7:0] bad_xor);
    logic [8*CS-1:0] d;
    load(base);
    for (int k = 0; k < CS; k++) begin
      if (busy && k == 1) begin
        issue(1'b0);
        chk(c_seen && c_addr == base + 16'(k), "R3 refused request", int'(c_addr), int'(base) + k);
        issue(1'b0);
        chk(c_seen && c_wdata == 8'(cur_seed + 8'(k)), "R3 retry same data",
            int'(c_wdata), int'(8'(cur_seed + 8'(k))));
      end
      write_step(base, k);
      if (poke && k == 2) begin
        issue(1'b1);
        chk(!c_seen, "R8 initiate while pending", int'(c_seen), 0);
      end
      respond('0);
    end
    read_step(base, d);
    if (bad_idx >= 0) d[8*bad_idx +: 8] = d[8*bad_idx +: 8] ^ bad_xor;
    respond(d);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int flushes;
    logic [15:0] pc;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    do_reset();
    chk(!req_valid && !error_flag, "R1 reset outputs", int'(error_flag), 0);
    chk(pass_count == 0 && err_kind == 2'd0, "R1 reset count", int'(pass_count), 0);

    // Table-driven runs, flush disabled (R9 off path covered by kind checks)
    for (int v = 0; v < 6; v++) begin
      run_check(VEC[v][17:2], VEC[v][1], VEC[v][0], -1, 8'h00);
      chk(pass_count == 16'(v + 1) && !error_flag, "R5 pass count", int'(pass_count), v + 1);
    end
    // R5: next run restarts at offset 0 of the base
    write_step(16'h00F0, 0);
    respond('0);

    // R6 mismatch
    do_reset();
    run_check(16'h0030, 1'b0, 1'b0, 2, 8'h10);
    chk(error_flag && err_kind == 2'd1, "R6 mismatch flag", int'(err_kind), 1);
    chk(err_index == 2'd2, "R6 mismatch index", int'(err_index), 2);
    chk(err_expected == 8'(cur_seed + 8'd2), "R6 expected byte", int'(err_expected), int'(8'(cur_seed + 8'd2)));
    chk(err_actual == (8'(cur_seed + 8'd2) ^ 8'h10), "R6 actual byte", int'(err_actual),
        int'(8'(cur_seed + 8'd2) ^ 8'h10));
    chk(pass_count == 0, "R6 count unchanged", int'(pass_count), 0);

    // R7 stray response in idle
    do_reset();
    respond('0);
    chk(error_flag && err_kind == 2'd2, "R7 unexpected in idle", int'(err_kind), 2);

    // R7 stray response in ready
    do_reset();
    load(16'h0060);
    for (int k = 0; k < CS; k++) begin write_step(16'h0060, k); respond('0); end
    respond('0);
    chk(error_flag && err_kind == 2'd2, "R7 unexpected in ready", int'(err_kind), 2);

    // R11 load in ready, then load ignored while pending
    do_reset();
    load(16'h0050);
    for (int k = 0; k < CS; k++) begin write_step(16'h0050, k); respond('0); end
    pc = 16'h0070;
    load(pc);
    issue(1'b1);
    chk(c_kind == 2'd0 && c_addr == pc && c_wdata == cur_seed, "R11 load in ready",
        int'(c_addr), int'(pc));
    respond('0);
    issue(1'b1);
    chk(c_addr == pc + 16'd1, "R11 second byte", int'(c_addr), int'(pc) + 1);
    load(16'h0090);
    respond('0);
    issue(1'b1);
    chk(c_addr == pc + 16'd2 && c_wdata == 8'(cur_seed + 8'd2), "R11 load ignored while pending",
        int'(c_addr), int'(pc) + 2);
    respond('0);
    chk(!error_flag, "R11 no error", int'(error_flag), 0);

    // R9 flush injection
    do_reset();
    load(16'h0040);
    flush_en = 1'b1;
    flushes = 0;
    for (int i = 0; i < 3000; i++) begin
      repeat (i % 3) @(negedge clk);
      issue(1'b0);
      if (c_kind == 2'd2) begin
        flushes++;
        chk(c_addr == 16'h0040 && c_len == 3'(CS) && int'(c_port) < NW, "R9 flush request",
            int'(c_addr), 16'h0040);
      end else begin
        chk(c_seen && c_kind == 2'd0 && c_addr == 16'h0040, "R9 sequence untouched",
            int'(c_addr), 16'h0040);
      end
    end
    chk(flushes > 0, "R9 some flush issued", flushes, 1);
    flush_en = 1'b0;
    chk(!error_flag, "R9 no error", int'(error_flag), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule